// File: doc/BRIEF.md
# Shared-Adder Reduction Unit

This block collapses a set of partial sums into one total. The operand count is the product of two parameters, the interleave depth and the lane count, and the block is built for the case where a pipelined accumulator has left one partial result per interleave slot and lane. Only a small, fixed pool of pipelined adders is available, and each adder takes several cycles to return its result. The unit therefore folds the operand set over several passes. In each pass it adds neighbouring values in pairs. It hands up to one new pair per adder to the pool every cycle. When every result of the pass has been written back, the next pass begins on the values that are left.

A client presents every operand at once on a wide bus and pulses start. The unit stores the operands in an internal register file and reuses that file in place from pass to pass. When the last pass retires, the unit raises done for one cycle. At that point the total and the number of cycles the job took are valid on the outputs, and they stay there until the next job completes. Additions wrap modulo the data width. The time taken depends only on the operand count, the adder count and the adder latency, so the cycle count output can be checked against a closed formula.

Top module: `redux_top`

## Requirements
- R1: While reset is asserted and after it is released with no job started, busy_o and done_o are 0 and sum_o and cycles_o read 0.
- R2: A start_i pulse while busy_o is low captures every operand at once, with operand i taken from ops_i bits [i*DATA_W +: DATA_W]. busy_o is high from the next cycle until the job completes.
- R3: When done_o is high, sum_o equals the sum of all captured operands modulo 2^DATA_W, so the result wraps on overflow.
- R4: Each pass adds the values at positions 2k and 2k+1 into position k. When a pass has an odd number of values, its last value moves unchanged to the first free position of the next pass. As a result, every operand position, including the last one, contributes exactly once to the total.
- R5: A pass issues its first addition only after every result of the previous pass has been written back. Within a pass, up to NUM_ADDERS additions issue per cycle, in ascending pair order.
- R6: With a start cycle s, done_o is high in cycle s + D. D = 1 + sum over passes of (ceil(pairs/NUM_ADDERS) + ADD_LAT + 1). A pass with m live values has floor(m/2) pairs and leaves ceil(m/2) values. The passes begin at m = ROWS*LANES and continue until one value remains.
- R7: In the done_o cycle, cycles_o equals D.
- R8: done_o is high for exactly one cycle per accepted start, and busy_o is low in that cycle.
- R9: A start_i pulse while busy_o is high is ignored. It neither disturbs the result of the running job nor launches a further job.
- R10: sum_o and cycles_o keep their values until the next completion. A start_i pulse in the done_o cycle is accepted as a new job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures ops_i when the unit is idle |
| ops_i | input | ROWS*LANES*DATA_W | All operands, operand i at bits [i*DATA_W +: DATA_W] |
| busy_o | output | 1 | High while a reduction is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sum_o | output | DATA_W | Total of the last completed job |
| cycles_o | output | CNT_W | Start-to-done cycle count of the last completed job |

## Verification
The hardest case to reach from the ports is an odd carry in a pass that moves a value which no other operand can mask. The bench loads a job in which only the last operand is nonzero, with an operand count chosen so that three of the passes are odd. The total is then correct only if the carried value survives every move. The level barrier and the in-place reuse of storage are both exposed through the exact done cycle, which the bench compares with its own pass-by-pass count. A second start is also pulsed partway through a job, with complemented data, to show that a busy unit ignores it.

// File: rtl/redux_pkg.sv
package redux_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_DRAIN
  } redux_state_e;

  // pairs formed from a pass holding `live` values
  function automatic int pair_count(input int live);
    return live / 2;
  endfunction

  // values remaining after a pass
  function automatic int next_live(input int live);
    return (live + 1) / 2;
  endfunction

  // cycles needed to hand every pair of a pass to the adder pool
  function automatic int issue_slots(input int live, input int adders);
    return (pair_count(live) + adders - 1) / adders;
  endfunction

  // start-to-done cycle count of a whole job
  function automatic int reduce_cycles(input int ops, input int adders, input int lat);
    int live;
    int total;
    live  = ops;
    total = 1;
    while (live > 1) begin
      total = total + issue_slots(live, adders) + lat + 1;
      live  = next_live(live);
    end
    return total;
  endfunction

endpackage

// File: rtl/redux_addpipe.sv
module redux_addpipe #(
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 8,
  parameter int ADD_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [IDX_W-1:0]  in_dst,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_sum,
  output logic [IDX_W-1:0]  out_dst
);

  function automatic logic [DATA_W-1:0] lane_add(input logic [DATA_W-1:0] x,
                                                  input logic [DATA_W-1:0] y);
    return x + y;
  endfunction

  logic              vld_q [ADD_LAT];
  logic [DATA_W-1:0] sum_q [ADD_LAT];
  logic [IDX_W-1:0]  dst_q [ADD_LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < ADD_LAT; s++) vld_q[s] <= 1'b0;
    end else begin
      vld_q[0] <= in_vld;
      for (int s = 1; s < ADD_LAT; s++) vld_q[s] <= vld_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    sum_q[0] <= lane_add(in_a, in_b);
    dst_q[0] <= in_dst;
    for (int s = 1; s < ADD_LAT; s++) begin
      sum_q[s] <= sum_q[s-1];
      dst_q[s] <= dst_q[s-1];
    end
  end

  assign out_vld = vld_q[ADD_LAT-1];
  assign out_sum = sum_q[ADD_LAT-1];
  assign out_dst = dst_q[ADD_LAT-1];

endmodule

// File: rtl/redux_regfile.sv
module redux_regfile #(
  parameter int DATA_W  = 32,
  parameter int NUM_OPS = 256,
  parameter int IDX_W   = 8,
  parameter int NUM_RD  = 9,
  parameter int NUM_WR  = 5
) (
  input  logic                             clk,
  input  logic                             load_en,
  input  logic [NUM_OPS*DATA_W-1:0]        load_data,
  input  logic [NUM_RD-1:0][IDX_W-1:0]     rd_idx,
  output logic [NUM_RD-1:0][DATA_W-1:0]    rd_dat,
  input  logic [NUM_WR-1:0]                wr_en,
  input  logic [NUM_WR-1:0][IDX_W-1:0]     wr_idx,
  input  logic [NUM_WR-1:0][DATA_W-1:0]    wr_dat,
  output logic [DATA_W-1:0]                head_dat
);

  logic [DATA_W-1:0] mem [NUM_OPS];

  always_ff @(posedge clk) begin
    if (load_en) begin
      for (int i = 0; i < NUM_OPS; i++) mem[i] <= load_data[i*DATA_W +: DATA_W];
    end else begin
      for (int w = 0; w < NUM_WR; w++) begin
        if (wr_en[w]) mem[wr_idx[w]] <= wr_dat[w];
      end
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign rd_dat[r] = mem[rd_idx[r]];
  end

  assign head_dat = mem[0];

endmodule

// File: rtl/redux_sched.sv
module redux_sched
  import redux_pkg::*;
#(
  parameter int NUM_OPS    = 256,
  parameter int NUM_ADDERS = 4,
  parameter int ADD_LAT    = 3,
  parameter int IDX_W      = 8,
  parameter int CNT_W      = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start_i,
  input  logic [NUM_ADDERS-1:0]              retire_vec,
  output logic                               load_en,
  output logic [NUM_ADDERS-1:0]              issue_vec,
  output logic [NUM_ADDERS-1:0][IDX_W-1:0]   pair_idx,
  output logic                               move_en,
  output logic [IDX_W-1:0]                   move_src,
  output logic [IDX_W-1:0]                   move_dst,
  output logic                               finish,
  output logic                               busy_o,
  output logic                               done_o,
  output logic [CNT_W-1:0]                   cycles_o,
  output logic                               lvl_start,
  output logic                               pipes_empty
);

  localparam int LIVE_W = $clog2(NUM_OPS + 1);
  localparam int PTR_W  = $clog2(NUM_OPS + NUM_ADDERS + 1);
  localparam int PEND_W = $clog2(NUM_ADDERS * (ADD_LAT + 1) + 1);

  redux_state_e       state;
  logic [LIVE_W-1:0]  live;
  logic [LIVE_W-1:0]  pairs;
  logic [LIVE_W-1:0]  live_nxt;
  logic [PTR_W-1:0]   ptr;
  logic [PEND_W-1:0]  pending;
  logic [PEND_W-1:0]  n_iss;
  logic [PEND_W-1:0]  n_ret;
  logic [CNT_W-1:0]   cnt;
  logic               drained;
  logic               last_slot;

  assign pairs    = LIVE_W'(pair_count(int'(live)));
  assign live_nxt = LIVE_W'(next_live(int'(live)));

  always_comb begin
    for (int j = 0; j < NUM_ADDERS; j++) begin
      issue_vec[j] = (state == ST_ISSUE) && ((ptr + PTR_W'(j)) < PTR_W'(pairs));
      pair_idx[j]  = issue_vec[j] ? IDX_W'(ptr + PTR_W'(j)) : '0;
    end
  end

  always_comb begin
    n_iss = '0;
    n_ret = '0;
    for (int j = 0; j < NUM_ADDERS; j++) begin
      n_iss = n_iss + PEND_W'(issue_vec[j]);
      n_ret = n_ret + PEND_W'(retire_vec[j]);
    end
  end

  assign pipes_empty = (pending == '0);
  assign drained     = (state == ST_DRAIN) && pipes_empty;
  assign last_slot   = (ptr + PTR_W'(NUM_ADDERS)) >= PTR_W'(pairs);
  assign move_en     = drained && live[0];
  assign move_src    = IDX_W'(live - 1'b1);
  assign move_dst    = IDX_W'(pairs);
  assign finish      = drained && (live_nxt == LIVE_W'(1));
  assign lvl_start   = (state == ST_ISSUE) && (ptr == '0);
  assign load_en     = start_i && (state == ST_IDLE);
  assign busy_o      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      live     <= '0;
      ptr      <= '0;
      pending  <= '0;
      cnt      <= '0;
      cycles_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o  <= finish;
      pending <= pending + n_iss - n_ret;
      if (state != ST_IDLE) cnt <= cnt + 1'b1;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            state <= ST_ISSUE;
            live  <= LIVE_W'(NUM_OPS);
            ptr   <= '0;
            cnt   <= CNT_W'(1);
          end
        end
        ST_ISSUE: begin
          ptr <= ptr + PTR_W'(NUM_ADDERS);
          if (last_slot) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (drained) begin
            live <= live_nxt;
            ptr  <= '0;
            if (finish) begin
              state    <= ST_IDLE;
              cycles_o <= cnt + 1'b1;
            end else begin
              state <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/redux_top.sv
module redux_top
  import redux_pkg::*;
#(
  parameter int ROWS       = 8,
  parameter int LANES      = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_ADDERS = 4,
  parameter int ADD_LAT    = 3,
  parameter int CNT_W      = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic [ROWS*LANES*DATA_W-1:0]   ops_i,
  output logic                           busy_o,
  output logic                           done_o,
  output logic [DATA_W-1:0]              sum_o,
  output logic [CNT_W-1:0]               cycles_o
);

  localparam int NUM_OPS = ROWS * LANES;
  localparam int IDX_W   = $clog2(NUM_OPS);
  localparam int NUM_RD  = 2 * NUM_ADDERS + 1;
  localparam int NUM_WR  = NUM_ADDERS + 1;

  logic                               load_en;
  logic [NUM_ADDERS-1:0]              issue_vec;
  logic [NUM_ADDERS-1:0]              retire_vec;
  logic [NUM_ADDERS-1:0][IDX_W-1:0]   pair_idx;
  logic                               move_en;
  logic [IDX_W-1:0]                   move_src;
  logic [IDX_W-1:0]                   move_dst;
  logic                               finish;
  logic                               lvl_start;
  logic                               pipes_empty;
  logic [NUM_RD-1:0][IDX_W-1:0]       rd_idx;
  logic [NUM_RD-1:0][DATA_W-1:0]      rd_dat;
  logic [NUM_WR-1:0]                  wr_en;
  logic [NUM_WR-1:0][IDX_W-1:0]       wr_idx;
  logic [NUM_WR-1:0][DATA_W-1:0]      wr_dat;
  logic [DATA_W-1:0]                  head_dat;

  redux_sched #(
    .NUM_OPS   (NUM_OPS),
    .NUM_ADDERS(NUM_ADDERS),
    .ADD_LAT   (ADD_LAT),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
  ) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .retire_vec (retire_vec),
    .load_en    (load_en),
    .issue_vec  (issue_vec),
    .pair_idx   (pair_idx),
    .move_en    (move_en),
    .move_src   (move_src),
    .move_dst   (move_dst),
    .finish     (finish),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .cycles_o   (cycles_o),
    .lvl_start  (lvl_start),
    .pipes_empty(pipes_empty)
  );

  for (genvar j = 0; j < NUM_ADDERS; j++) begin : g_lane
    assign rd_idx[2*j]   = pair_idx[j] << 1;
    assign rd_idx[2*j+1] = (pair_idx[j] << 1) | IDX_W'(1);
    assign wr_en[j]      = retire_vec[j];

    redux_addpipe #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W),
      .ADD_LAT(ADD_LAT)
    ) u_add (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_vld (issue_vec[j]),
      .in_a   (rd_dat[2*j]),
      .in_b   (rd_dat[2*j+1]),
      .in_dst (pair_idx[j]),
      .out_vld(retire_vec[j]),
      .out_sum(wr_dat[j]),
      .out_dst(wr_idx[j])
    );
  end

  // odd carry port: last value of a pass moves to the next pass's tail
  assign rd_idx[NUM_RD-1]  = move_src;
  assign wr_en[NUM_WR-1]   = move_en;
  assign wr_idx[NUM_WR-1]  = move_dst;
  assign wr_dat[NUM_WR-1]  = rd_dat[NUM_RD-1];

  redux_regfile #(
    .DATA_W (DATA_W),
    .NUM_OPS(NUM_OPS),
    .IDX_W  (IDX_W),
    .NUM_RD (NUM_RD),
    .NUM_WR (NUM_WR)
  ) u_rf (
    .clk      (clk),
    .load_en  (load_en),
    .load_data(ops_i),
    .rd_idx   (rd_idx),
    .rd_dat   (rd_dat),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_dat   (wr_dat),
    .head_dat (head_dat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_o <= '0;
    else if (finish) sum_o <= head_dat;
  end

endmodule

// File: rtl/redux_checker.sv
module redux_checker
  import redux_pkg::*;
#(
  parameter int NUM_OPS    = 256,
  parameter int NUM_ADDERS = 4,
  parameter int ADD_LAT    = 3,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_i,
  input logic                  busy_o,
  input logic                  done_o,
  input logic [DATA_W-1:0]     sum_o,
  input logic [CNT_W-1:0]      cycles_o,
  input logic                  lvl_start,
  input logic                  pipes_empty,
  input logic                  load_en,
  input logic [NUM_ADDERS-1:0] retire_vec
);

  localparam int EXP_CYC = reduce_cycles(NUM_OPS, NUM_ADDERS, ADD_LAT);

  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_level_no_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_start |-> (retire_vec == '0));

  assert_level_barrier_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_start |-> pipes_empty);

  assert_cycle_report_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cycles_o == CNT_W'(EXP_CYC)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_no_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !load_en);

  assert_sum_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(sum_o));

endmodule

bind redux_top redux_checker #(
  .NUM_OPS   (NUM_OPS),
  .NUM_ADDERS(NUM_ADDERS),
  .ADD_LAT   (ADD_LAT),
  .DATA_W    (DATA_W),
  .CNT_W     (CNT_W)
) u_redux_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .sum_o      (sum_o),
  .cycles_o   (cycles_o),
  .lvl_start  (lvl_start),
  .pipes_empty(pipes_empty),
  .load_en    (load_en),
  .retire_vec (retire_vec)
);

// File: tb/test_redux_top.sv
`timescale 1ns/1ps
module test_redux_top;

  localparam int ROWS       = 5;
  localparam int LANES      = 5;
  localparam int DATA_W     = 32;
  localparam int NUM_ADDERS = 3;
  localparam int ADD_LAT    = 4;
  localparam int CNT_W      = 16;
  localparam int NOPS       = ROWS * LANES;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic                     start_i = 1'b0;
  logic [NOPS*DATA_W-1:0]   ops_i = '0;
  logic                     busy_o;
  logic                     done_o;
  logic [DATA_W-1:0]        sum_o;
  logic [CNT_W-1:0]         cycles_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int dones = 0;
  int jobs = 0;
  logic prev_done = 1'b0;

  logic [DATA_W-1:0] exp_sum_q [$];
  int                exp_lat_q [$];
  int                start_cyc_q [$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  redux_top #(
    .ROWS      (ROWS),
    .LANES     (LANES),
    .DATA_W    (DATA_W),
    .NUM_ADDERS(NUM_ADDERS),
    .ADD_LAT   (ADD_LAT),
    .CNT_W     (CNT_W)
  ) i_redux_top (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .ops_i   (ops_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .sum_o   (sum_o),
    .cycles_o(cycles_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // pass-by-pass latency, counted from the values left after each pass
  function automatic int model_latency();
    int left;
    int total;
    left  = NOPS;
    total = 1;
    while (left > 1) begin
      int p;
      p     = left / 2;
      total = total + (p + NUM_ADDERS - 1) / NUM_ADDERS + ADD_LAT + 1;
      left  = left - p;
    end
    return total;
  endfunction

  // driver: called right after a falling edge
  task automatic drive_job(input logic [NOPS*DATA_W-1:0] bus, input bit poke);
    logic [DATA_W-1:0] acc;
    acc = '0;
    for (int i = NOPS - 1; i >= 0; i--) acc = acc + bus[i*DATA_W +: DATA_W];
    exp_sum_q.push_back(acc);
    exp_lat_q.push_back(model_latency());
    start_cyc_q.push_back(cyc);
    jobs++;
    ops_i   = bus;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R2 R10", "busy after accepted start", busy_o, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      ops_i   = ~bus;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
  endtask

  // monitor: scoreboard compare on each completion
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        dones++;
        if (exp_sum_q.size() == 0) begin
          check(1'b0, "R8", "done without pending job", dones, jobs);
        end else begin
          logic [DATA_W-1:0] es;
          int el;
          int sc;
          es = exp_sum_q.pop_front();
          el = exp_lat_q.pop_front();
          sc = start_cyc_q.pop_front();
          check(sum_o == es, "R3", "total", sum_o, es);
          check(int'(cycles_o) == el, "R7", "reported cycles", cycles_o, el);
          check((cyc - sc) == el, "R5 R6", "done cycle offset", cyc - sc, el);
          check(busy_o == 1'b0, "R8", "busy in done cycle", busy_o, 0);
        end
        if (prev_done) check(1'b0, "R8", "done longer than one cycle", 2, 1);
      end
      prev_done = done_o;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R6 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [NOPS*DATA_W-1:0] bus;
    logic [DATA_W-1:0] held_sum;
    logic [CNT_W-1:0]  held_cyc;
    logic [31:0]       seed;

    repeat (3) @(negedge clk);
    check(busy_o == 1'b0 && done_o == 1'b0, "R1", "flags in reset", {busy_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
    check(done_o == 1'b0, "R1", "done after reset", done_o, 0);
    check(sum_o == '0, "R1", "sum after reset", sum_o, 0);
    check(cycles_o == '0, "R1", "cycles after reset", cycles_o, 0);

    // ascending ramp 1..NOPS
    for (int i = 0; i < NOPS; i++) bus[i*DATA_W +: DATA_W] = DATA_W'(i + 1);
    drive_job(bus, 1'b0);
    check(sum_o == DATA_W'(NOPS * (NOPS + 1) / 2), "R3", "ramp total", sum_o, NOPS * (NOPS + 1) / 2);

    // all ones: wraps modulo 2^DATA_W
    bus = '1;
    repeat (2) @(negedge clk);
    drive_job(bus, 1'b0);
    check(sum_o == DATA_W'(-NOPS), "R3", "wrapped total", sum_o, DATA_W'(-NOPS));

    // only the last operand set: travels through odd carries
    bus = '0;
    bus[(NOPS-1)*DATA_W +: DATA_W] = 32'h0000_1234;
    repeat (2) @(negedge clk);
    drive_job(bus, 1'b0);
    check(sum_o == 32'h0000_1234, "R4", "last operand carried", sum_o, 32'h1234);

    // only the first operand set
    bus = '0;
    bus[0 +: DATA_W] = 32'h00AB_CDEF;
    repeat (2) @(negedge clk);
    drive_job(bus, 1'b0);
    check(sum_o == 32'h00AB_CDEF, "R4", "first operand kept", sum_o, 32'h00AB_CDEF);

    // hold between completions
    held_sum = sum_o;
    held_cyc = cycles_o;
    repeat (10) @(negedge clk);
    check(sum_o == held_sum, "R10", "sum held", sum_o, held_sum);
    check(cycles_o == held_cyc, "R10", "cycles held", cycles_o, held_cyc);

    // pseudo-random data
    seed = 32'h1357_9BDF;
    for (int i = 0; i < NOPS; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      bus[i*DATA_W +: DATA_W] = seed;
    end
    drive_job(bus, 1'b0);

    // back to back: new start in the done cycle
    for (int i = 0; i < NOPS; i++) bus[i*DATA_W +: DATA_W] = DATA_W'((NOPS - i) * 1000);
    drive_job(bus, 1'b0);

    // start pulsed while busy must be ignored
    for (int i = 0; i < NOPS; i++) bus[i*DATA_W +: DATA_W] = DATA_W'(i * 7 + 3);
    repeat (2) @(negedge clk);
    drive_job(bus, 1'b1);
    repeat (60) @(negedge clk);
    check(busy_o == 1'b0, "R9", "no extra job after ignored start", busy_o, 0);
    check(dones == jobs, "R9", "completion count", dones, jobs);
    check(exp_sum_q.size() == 0, "R8", "scoreboard drained", exp_sum_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule